// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block is the digital front end of a display column driver. Each clock, a 48-bit bus brings six 8-bit gray values. A single-bit token, started by a start pulse, walks through a 64-stage shift register. On the edge where the token enters a stage, that stage's six-value group is written into a 384-entry column data register, so a full line takes 64 clocks.

A direction input chooses which end of the column range fills first and which start pin is the input. The opposite pin then passes the token on to the next chip in a chain. It does this exactly 64 clocks after the accepted start.

Once per line, a strobe works on two edges. Its rising edge copies the column data register into an output latch. Its falling edge raises an output-valid flag. A polarity input exchanges the latched values between each odd and even column pair.

Top module: `lcdColumnLoader`

## Requirements
- R1: With `dirRight` high, the start edge writes group 0 and each following clock writes the next group, up to group 63. Dot d of group g (bits 8d+7 down to 8d of `pixData`, bit 8d being the LSB) lands in column 6g+d+1. Column c (1-based) appears on `colOut` bits 8c-1 down to 8c-8 once latched.
- R2: With `dirRight` low, dot d of group g lands in column 384-6g-d, so filling runs from column 384 toward column 1.
- R3: `startRightIn` is the start input when `dirRight` is high and `startLeftIn` is ignored. When `dirRight` is low, `startLeftIn` is the start input and `startRightIn` is ignored. A start is sampled on the rising clock edge.
- R4: The output pin opposite the active input (`startLeftOut` for `dirRight` high, `startRightOut` for low) goes high for exactly one clock. It rises on the 64th rising edge after the edge that accepted the start. The other output pin stays low.
- R5: After the token has been passed on, no column is written until a new start pulse is accepted.
- R6: A strobe rising edge (strobe high, low on the previous clock edge) copies the whole data register into the latch. At no other time does the latch change. If a group write falls on that same edge, the latch takes the value that group held before the write.
- R7: The strobe rising edge clears `outValid` and the strobe falling edge sets it, each effective from that clock edge.
- R8: With `polarity` high, columns 2n-1 and 2n show each other's latched values. With `polarity` low, each column shows its own.
- R9: Synchronous active-high `rst` clears the token, both start outputs, the data register, the latch and `outValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| dirRight | input | 1 | Fill direction and start-pin role select |
| startRightIn | input | 1 | Start pulse input used when dirRight is high |
| startLeftIn | input | 1 | Start pulse input used when dirRight is low |
| pixData | input | 48 | Six 8-bit gray values per clock |
| strobe | input | 1 | Line strobe: rise latches, fall validates |
| polarity | input | 1 | Swap odd/even column pairs |
| startRightOut | output | 1 | Token pass-on pulse when dirRight is low |
| startLeftOut | output | 1 | Token pass-on pulse when dirRight is high |
| colOut | output | 3072 | 384 latched gray values, column 1 in the lowest byte |
| outValid | output | 1 | High from the strobe falling edge to the next rising edge |

## Verification
The latch transfer and the group write can happen on the same clock edge. The bench provokes this by raising the strobe so that its rising edge is sampled on the edge that writes group 63. It judges the result by expecting the new values in groups 0 to 62 and the previous line's values in group 63. A second strobe must then reveal the new group 63. The token pass-on and a new start can also coincide. A checker counter follows every accepted start independently, so a pass-on pulse must appear even when a fresh start arrives on the same edge.

// File: rtl/lcdLoaderPkg.sv
package lcdLoaderPkg;
  typedef struct packed {
    logic latchLoad;
    logic validSet;
    logic validClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/lcdLoaderCtrl.sv
module lcdLoaderCtrl
  import lcdLoaderPkg::*;
#(
  parameter int GROUPS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic              strobeIn,
  output logic [GROUPS-1:0] grpWe,
  output logic              passOut,
  output ctrlStrobes_t      strobes
);
  logic [GROUPS-1:0] tok;
  logic              strbPrev;

  // token enters stage 0 on an accepted start, else moves one stage on
  always_comb begin
    if (startIn) grpWe = {{(GROUPS-1){1'b0}}, 1'b1};
    else         grpWe = {tok[GROUPS-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tok     <= '0;
      passOut <= 1'b0;
    end else begin
      tok     <= grpWe;
      passOut <= tok[GROUPS-1];
    end
  end

  always_ff @(posedge clk) strbPrev <= strobeIn;

  always_comb begin
    strobes.latchLoad = strobeIn & ~strbPrev;
    strobes.validClr  = strobeIn & ~strbPrev;
    strobes.validSet  = ~strobeIn & strbPrev;
  end
endmodule

// File: rtl/lcdLoaderData.sv
module lcdLoaderData
  import lcdLoaderPkg::*;
#(
  parameter int GRAY_W = 8,
  parameter int DOTS   = 6,
  parameter int GROUPS = 64,
  localparam int COLS  = GROUPS * DOTS,
  localparam int BUS_W = GRAY_W * DOTS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dirRight,
  input  logic                   polarity,
  input  logic [BUS_W-1:0]       pixData,
  input  logic [GROUPS-1:0]      grpWe,
  input  ctrlStrobes_t           strobes,
  output logic [COLS*GRAY_W-1:0] colOut,
  output logic                   outValid
);
  logic [COLS*GRAY_W-1:0] latchVec;

  for (genvar c = 0; c < COLS; c++) begin : gCol
    localparam int GR   = c / DOTS;
    localparam int DR   = c % DOTS;
    localparam int CL   = COLS - 1 - c;
    localparam int GL   = CL / DOTS;
    localparam int DL   = CL % DOTS;
    localparam int PEER = c ^ 1;
    logic              we;
    logic [GRAY_W-1:0] din, dReg, lReg;

    assign we  = dirRight ? grpWe[GR] : grpWe[GL];
    assign din = dirRight ? pixData[DR*GRAY_W +: GRAY_W]
                          : pixData[DL*GRAY_W +: GRAY_W];

    always_ff @(posedge clk) begin
      if (rst)     dReg <= '0;
      else if (we) dReg <= din;
    end

    always_ff @(posedge clk) begin
      if (rst)                    lReg <= '0;
      else if (strobes.latchLoad) lReg <= dReg;
    end

    assign latchVec[c*GRAY_W +: GRAY_W] = lReg;
    assign colOut[c*GRAY_W +: GRAY_W] =
      polarity ? latchVec[PEER*GRAY_W +: GRAY_W] : lReg;
  end

  always_ff @(posedge clk) begin
    if (rst)                   outValid <= 1'b0;
    else if (strobes.validClr) outValid <= 1'b0;
    else if (strobes.validSet) outValid <= 1'b1;
  end
endmodule

// File: rtl/lcdColumnLoader.sv
module lcdColumnLoader
  import lcdLoaderPkg::*;
#(
  parameter int GRAY_W = 8,
  parameter int DOTS   = 6,
  parameter int GROUPS = 64,
  localparam int COLS  = GROUPS * DOTS,
  localparam int BUS_W = GRAY_W * DOTS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dirRight,
  input  logic                   startRightIn,
  input  logic                   startLeftIn,
  input  logic [BUS_W-1:0]       pixData,
  input  logic                   strobe,
  input  logic                   polarity,
  output logic                   startRightOut,
  output logic                   startLeftOut,
  output logic [COLS*GRAY_W-1:0] colOut,
  output logic                   outValid
);
  logic              startSel, passOut;
  logic [GROUPS-1:0] grpWe;
  ctrlStrobes_t      strobes;

  assign startSel      = dirRight ? startRightIn : startLeftIn;
  assign startLeftOut  = dirRight & passOut;
  assign startRightOut = ~dirRight & passOut;

  lcdLoaderCtrl #(.GROUPS(GROUPS)) ctrl_i (
    .clk(clk), .rst(rst), .startIn(startSel), .strobeIn(strobe),
    .grpWe(grpWe), .passOut(passOut), .strobes(strobes)
  );

  lcdLoaderData #(.GRAY_W(GRAY_W), .DOTS(DOTS), .GROUPS(GROUPS)) data_i (
    .clk(clk), .rst(rst), .dirRight(dirRight), .polarity(polarity),
    .pixData(pixData), .grpWe(grpWe), .strobes(strobes),
    .colOut(colOut), .outValid(outValid)
  );
endmodule

// File: rtl/lcdColumnLoaderChk.sv
module lcdColumnLoaderChk #(
  parameter int GROUPS = 64,
  parameter int OUT_W  = 3072,
  localparam int CW    = $clog2(GROUPS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             dirRight,
  input logic             startRightIn,
  input logic             startLeftIn,
  input logic             strobe,
  input logic             polarity,
  input logic [OUT_W-1:0] colOut,
  input logic             outValid,
  input logic             startRightOut,
  input logic             startLeftOut
);
  logic [CW-1:0] cnt;
  logic          fireExp, startSel;

  assign startSel = dirRight ? startRightIn : startLeftIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      fireExp <= 1'b0;
    end else begin
      fireExp <= (cnt == CW'(GROUPS));
      if (startSel)                              cnt <= CW'(1);
      else if (cnt != '0 && cnt != CW'(GROUPS)) cnt <= cnt + CW'(1);
      else                                       cnt <= '0;
    end
  end

  // R4
  pass_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (startLeftOut | startRightOut) == fireExp);

  // R4
  pass_single_chk: assert property (@(posedge clk) disable iff (rst)
    (startLeftOut | startRightOut) |=> !(startLeftOut | startRightOut));

  // R4
  pass_pin_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({startLeftOut, startRightOut}));

  // R7
  valid_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |=> !outValid);

  // R7
  valid_set_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe) |=> outValid);

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(strobe) |=> ($stable(colOut) || !$stable(polarity)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && !startLeftOut && !startRightOut));
endmodule

bind lcdColumnLoader lcdColumnLoaderChk #(.GROUPS(GROUPS), .OUT_W(COLS*GRAY_W)) chk_i (
  .clk(clk), .rst(rst), .dirRight(dirRight), .startRightIn(startRightIn),
  .startLeftIn(startLeftIn), .strobe(strobe), .polarity(polarity),
  .colOut(colOut), .outValid(outValid), .startRightOut(startRightOut),
  .startLeftOut(startLeftOut)
);

// File: tb/lcdColumnLoader_tb_top.sv
module lcdColumnLoader_tb_top;
  localparam int COLS = 384;
  localparam int GRPS = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dirRight = 1'b1;
  logic          startRightIn = 1'b0;
  logic          startLeftIn = 1'b0;
  logic [47:0]   pixData = '0;
  logic          strobe = 1'b0;
  logic          polarity = 1'b0;
  logic          startRightOut, startLeftOut, outValid;
  logic [3071:0] colOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] regImg [COLS];
  logic [7:0] latchImg [COLS];

  lcdColumnLoader dut_i (
    .clk(clk), .rst(rst), .dirRight(dirRight), .startRightIn(startRightIn),
    .startLeftIn(startLeftIn), .pixData(pixData), .strobe(strobe),
    .polarity(polarity), .startRightOut(startRightOut),
    .startLeftOut(startLeftOut), .colOut(colOut), .outValid(outValid)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] grayVal(input int seed, input int g, input int d);
    return 8'(seed * 37 + g * 13 + d * 59 + g * d);
  endfunction

  // drive group g of a line and record where the model expects it
  task automatic putGroup(input bit right, input int seed, input int g);
    for (int d = 0; d < 6; d++) begin
      logic [7:0] v = grayVal(seed, g, d);
      pixData[d*8 +: 8] = v;
      if (right) regImg[6*g + d] = v;
      else       regImg[COLS - 1 - 6*g - d] = v;
    end
  endtask

  task automatic compareCols(input string req);
    int bad = 0;
    int firstC = -1;
    for (int c = 0; c < COLS; c++) begin
      int src = polarity ? (c ^ 1) : c;
      if (colOut[c*8 +: 8] !== latchImg[src]) begin
        bad++;
        if (firstC < 0) firstC = c;
      end
    end
    nChecks++;
    if (bad != 0) begin
      nFails++;
      $display("FAIL %s column %0d actual=%0d expected=%0d (%0d columns wrong)", req,
               firstC + 1, colOut[firstC*8 +: 8], latchImg[polarity ? (firstC ^ 1) : firstC], bad);
    end
  endtask

  task automatic loadLine(input bit right, input int seed, input bit strobeAtLast);
    @(negedge clk);
    dirRight = right;
    if (right) startRightIn = 1'b1; else startLeftIn = 1'b1;
    putGroup(right, seed, 0);
    for (int g = 1; g < GRPS; g++) begin
      @(negedge clk);
      startRightIn = 1'b0;
      startLeftIn  = 1'b0;
      if (g == GRPS - 1 && strobeAtLast) begin
        strobe = 1'b1;
        for (int c = 0; c < COLS; c++) latchImg[c] = regImg[c];
      end
      putGroup(right, seed, g);
    end
    @(negedge clk);  // after edge 63
    chk("R4 no early pass", int'(startLeftOut | startRightOut), 0);
    pixData = 48'hA5A5_5A5A_F00F;
    @(negedge clk);  // after edge 64
    chk("R4 pass on far pin", int'(right ? startLeftOut : startRightOut), 1);
    chk("R4 near pin quiet", int'(right ? startRightOut : startLeftOut), 0);
    @(negedge clk);
    chk("R4 single clock pass", int'(startLeftOut | startRightOut), 0);
  endtask

  task automatic doStrobe(input string req);
    @(negedge clk);
    strobe = 1'b1;
    @(negedge clk);
    for (int c = 0; c < COLS; c++) latchImg[c] = regImg[c];
    chk("R7 rise clears valid", int'(outValid), 0);
    compareCols(req);
    strobe = 1'b0;
    @(negedge clk);
    chk("R7 fall sets valid", int'(outValid), 1);
  endtask

  task automatic testReset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < COLS; c++) begin
      regImg[c] = 8'h00;
      latchImg[c] = 8'h00;
    end
    chk("R9 valid low", int'(outValid), 0);
    chk("R9 pass pins low", int'(startLeftOut | startRightOut), 0);
    compareCols("R9 latch cleared");
  endtask

  task automatic testRightLine;
    loadLine(1'b1, 1, 1'b0);
    doStrobe("R1 right fill mapping");
    chk("R1 column 1 is group0 dot0", int'(colOut[7:0]), int'(grayVal(1, 0, 0)));
  endtask

  task automatic testPolarity;
    @(negedge clk);
    polarity = 1'b1;
    #1;
    compareCols("R8 swapped pairs");
    chk("R8 column 1 shows column 2", int'(colOut[7:0]), int'(grayVal(1, 0, 1)));
    polarity = 1'b0;
    #1;
    compareCols("R8 restored");
  endtask

  task automatic testLeftLine;
    loadLine(1'b0, 2, 1'b0);
    doStrobe("R2 left fill mapping");
    chk("R2 column 384 is group0 dot0", int'(colOut[3071:3064]), int'(grayVal(2, 0, 0)));
  endtask

  task automatic testIgnoredAndIdle;
    int passSeen = 0;
    @(negedge clk);
    dirRight = 1'b0;
    startRightIn = 1'b1;   // wrong pin for this direction
    pixData = 48'h1122_3344_5566;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      startRightIn = 1'b0;
      pixData = {8{6'(i)}};
      passSeen += int'(startLeftOut | startRightOut);
    end
    chk("R3 ignored pin gives no pass", passSeen, 0);
    doStrobe("R5 R3 no writes while idle");
  endtask

  task automatic testCoincide;
    loadLine(1'b1, 3, 1'b1);
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    chk("R7 valid after late fall", int'(outValid), 1);
    compareCols("R6 same-edge write keeps old group 63");
    chk("R6 column 384 old", int'(colOut[3071:3064]), int'(grayVal(2, 0, 0)));
    doStrobe("R6 second strobe shows new group 63");
  endtask

  task automatic testMidReset;
    int passSeen = 0;
    @(negedge clk);
    dirRight = 1'b1;
    startRightIn = 1'b1;
    pixData = 48'hFFFF_FFFF_FFFF;
    @(negedge clk);
    startRightIn = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < COLS; c++) latchImg[c] = 8'h00;
    chk("R9 mid reset clears valid", int'(outValid), 0);
    compareCols("R9 mid reset clears latch");
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      passSeen += int'(startLeftOut | startRightOut);
    end
    chk("R9 token cleared", passSeen, 0);
    for (int c = 0; c < COLS; c++) regImg[c] = 8'h00;
    doStrobe("R9 data register cleared");
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testRightLine();
    testPolarity();
    testLeftLine();
    testIgnoredAndIdle();
    testCoincide();
    testMidReset();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule